// File: doc/BRIEF.md
# Transfer-Engine Event Interrupt Controller

This block gathers single-cycle event pulses from a small number of transfer engines and holds each one as a sticky flag in a 32-bit status word. Each engine owns one 8-bit lane of that word. The low five bits of a lane carry five events: command done, receive overrun, transmit underrun, poll timeout and invalid control. The other three bits of each lane, and any lane with no engine behind it, are not implemented.

Software reaches the block through a plain register port. It reads the status word, clears flags by writing ones to them, and programs an enable mask. A read-only view shows the status with the mask applied. One interrupt line goes high whenever any enabled flag is pending. The line comes from a register, so it follows the flags one cycle later.

Top module: `evtirq_ctrl`

## Requirements
- R1: After a synchronous active-low reset, the status word, the mask and `irq_o` are all zero.
- R2: A pulse on `evt_pulse[i*5+j]` sets status bit `i*8+j`, for engine i and event code j. The codes are 0 command done, 1 receive overrun, 2 transmit underrun, 3 poll timeout and 4 invalid control. The bit stays set until it is cleared.
- R3: Writing to offset 0x08 clears each status bit whose written data bit is one. Bits written with zero keep their value.
- R4: If an event pulse and a clear hit the same bit in the same cycle, the bit ends up set.
- R5: A read of offset 0x0C returns the status word ANDed with the mask. It reads zero when no enabled flag is pending.
- R6: Offset 0x10 is the mask register, which can be written and read back. While it is zero, `irq_o` stays low.
- R7: `irq_o` equals the OR of all masked status bits as they stood one cycle earlier.
- R8: Bits that are not implemented read as zero, and writes to them are ignored. Writing 0xFF001F1F to offset 0x08 clears every flag.
- R9: Writes to offset 0x0C and to offsets outside 0x08, 0x0C and 0x10 change no state. Reads of such unmapped offsets return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| evt_pulse | input | NUM_ENG*5 | Event pulses, five per engine |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register byte offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| irq_o | output | 1 | Registered interrupt request |

## Verification
Random traffic mixes sparse event pulses with writes to all three registers and to unmapped offsets. Random write data is spread across the whole 32-bit word, so a design that keeps unimplemented bits or confuses clear with set shows up quickly. Directed cases cover separate points:
- a same-cycle set and clear, which decides the R4 priority;
- the 0xFF001F1F clear-all;
- a zero mask with flags pending, which separates the raw view from the masked view and the interrupt;
- writes to the read-only view and to unmapped offsets.

// File: rtl/evtirq_pkg.sv
// Shared constants for the event interrupt controller.
// Assumes byte offsets on the register port and 32-bit registers.
package evtirq_pkg;
    localparam int unsigned LANE_W   = 8;
    localparam int unsigned EVT_N    = 5;
    localparam int unsigned DATA_W   = 32;
    localparam logic [7:0]  OFF_RAW  = 8'h08;
    localparam logic [7:0]  OFF_VIEW = 8'h0C;
    localparam logic [7:0]  OFF_MASK = 8'h10;
endpackage

// File: rtl/evtirq_lane.sv
// One engine's lane: sticky event flags plus their enable bits.
// Assumes set has priority over clear in the same cycle.
module evtirq_lane
    import evtirq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [EVT_N-1:0] set_i,
    input  logic [EVT_N-1:0] clr_i,
    input  logic             mask_we,
    input  logic [EVT_N-1:0] mask_wd,
    output logic [EVT_N-1:0] flags_o,
    output logic [EVT_N-1:0] mask_o
);
    // Sticky flags: clear by ones, then OR in new events (set wins).
    always_ff @(posedge clk) begin
        if (!rst_n) flags_o <= '0;
        else        flags_o <= (flags_o & ~clr_i) | set_i;
    end

    // Enable bits, loaded on a mask register write.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_o <= '0;
        else if (mask_we) mask_o <= mask_wd;
    end
endmodule

// File: rtl/evtirq_rdmux.sv
// Read-data selection for the three mapped registers.
// Assumes unmapped offsets read zero; purely combinational.
module evtirq_rdmux
    import evtirq_pkg::*;
#(
    parameter int unsigned ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] raw_word,
    input  logic [DATA_W-1:0] mask_word,
    output logic [DATA_W-1:0] rdata
);
    localparam logic [ADDR_W-1:0] A_RAW  = ADDR_W'(OFF_RAW);
    localparam logic [ADDR_W-1:0] A_VIEW = ADDR_W'(OFF_VIEW);
    localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(OFF_MASK);

    // Offset decode for reads.
    always_comb begin
        case (addr)
            A_RAW:   rdata = raw_word;
            A_VIEW:  rdata = raw_word & mask_word;
            A_MASK:  rdata = mask_word;
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/evtirq_irqreg.sv
// Registers the OR of the masked flags onto the interrupt line.
// Assumes one cycle of latency is acceptable to the consumer.
module evtirq_irqreg
    import evtirq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] pend_i,
    output logic              irq_o
);
    // One flop after the reduction.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_o <= 1'b0;
        else        irq_o <= |pend_i;
    end
endmodule

// File: rtl/evtirq_ctrl.sv
// Top of the event interrupt controller: one lane per engine, the
// register port decode, and the registered interrupt output.
// Assumes NUM_ENG*8 <= 32 and a single-cycle write strobe.
module evtirq_ctrl
    import evtirq_pkg::*;
#(
    parameter int unsigned NUM_ENG = 2,
    parameter int unsigned ADDR_W  = 5
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_ENG*EVT_N-1:0] evt_pulse,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [DATA_W-1:0]        wdata,
    output logic [DATA_W-1:0]        rdata,
    output logic                     irq_o
);
    localparam logic [ADDR_W-1:0] A_RAW  = ADDR_W'(OFF_RAW);
    localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(OFF_MASK);

    logic              raw_we;
    logic              mask_we;
    logic [EVT_N-1:0]  lane_flags [NUM_ENG];
    logic [EVT_N-1:0]  lane_mask  [NUM_ENG];
    logic [DATA_W-1:0] raw_word;
    logic [DATA_W-1:0] mask_word;

    // Write decode: only the status and mask offsets take writes.
    always_comb begin
        raw_we  = wr_en && (addr == A_RAW);
        mask_we = wr_en && (addr == A_MASK);
    end

    for (genvar g = 0; g < NUM_ENG; g++) begin : g_lane
        evtirq_lane u_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_i   (evt_pulse[g*EVT_N +: EVT_N]),
            .clr_i   (raw_we ? wdata[g*LANE_W +: EVT_N] : '0),
            .mask_we (mask_we),
            .mask_wd (wdata[g*LANE_W +: EVT_N]),
            .flags_o (lane_flags[g]),
            .mask_o  (lane_mask[g])
        );
    end

    // Pack the lanes into 32-bit words; unimplemented bits stay zero.
    always_comb begin
        raw_word  = '0;
        mask_word = '0;
        for (int i = 0; i < NUM_ENG; i++) begin
            raw_word[i*LANE_W +: EVT_N]  = lane_flags[i];
            mask_word[i*LANE_W +: EVT_N] = lane_mask[i];
        end
    end

    evtirq_rdmux #(.ADDR_W(ADDR_W)) u_rdmux (
        .addr      (addr),
        .raw_word  (raw_word),
        .mask_word (mask_word),
        .rdata     (rdata)
    );

    evtirq_irqreg u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .pend_i (raw_word & mask_word),
        .irq_o  (irq_o)
    );
endmodule

// File: rtl/evtirq_ctrl_chk.sv
// Checker for evtirq_ctrl, bound to every instance of the top.
// Assumes it sees the packed status and mask words of the top.
module evtirq_ctrl_chk
    import evtirq_pkg::*;
#(
    parameter int unsigned NUM_ENG = 2,
    parameter int unsigned ADDR_W  = 5
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [NUM_ENG*EVT_N-1:0] evt_pulse,
    input logic                     wr_en,
    input logic [ADDR_W-1:0]        addr,
    input logic [DATA_W-1:0]        rdata,
    input logic [DATA_W-1:0]        raw_word,
    input logic [DATA_W-1:0]        mask_word,
    input logic                     irq_o
);
    logic [DATA_W-1:0] evt_word;
    logic [DATA_W-1:0] impl;

    // Spread the event pulses to their status bit positions.
    always_comb begin
        evt_word = '0;
        impl     = '0;
        for (int i = 0; i < NUM_ENG; i++) begin
            evt_word[i*LANE_W +: EVT_N] = evt_pulse[i*EVT_N +: EVT_N];
            impl[i*LANE_W +: EVT_N]     = '1;
        end
    end

    // R2 and R4: a pulse always leaves its bit set in the next cycle.
    p_evt_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_word != '0) |=> ((raw_word & $past(evt_word)) == $past(evt_word)));

    // R3: with no status write and no event, the flags hold.
    p_flags_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!(wr_en && addr == ADDR_W'(OFF_RAW)) && evt_word == '0) |=> $stable(raw_word));

    // R6: with a zero mask the interrupt is low one cycle later.
    p_mask_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_word == '0) |=> !irq_o);

    // R7: the interrupt tracks the previous cycle's masked pending state.
    p_irq_lag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_o == $past(|(raw_word & mask_word))));

    // R8: read data never shows unimplemented bits.
    p_unimpl_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((rdata & ~impl) == '0));

    // R9: a write outside the status and mask offsets leaves the mask alone.
    p_mask_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && addr == ADDR_W'(OFF_MASK)) |=> $stable(mask_word));
endmodule

bind evtirq_ctrl evtirq_ctrl_chk #(.NUM_ENG(NUM_ENG), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_pulse (evt_pulse),
    .wr_en     (wr_en),
    .addr      (addr),
    .rdata     (rdata),
    .raw_word  (raw_word),
    .mask_word (mask_word),
    .irq_o     (irq_o)
);

// File: tb/evtirq_ctrl_test.sv
`timescale 1ns/1ps
// Self-checking bench: a reference model in bench code, random traffic
// from a fixed seed, and directed corner cases.
module evtirq_ctrl_test;
    localparam int NE = 2;
    localparam int AW = 5;
    localparam logic [31:0] IMPL = 32'h0000_1F1F;

    logic           clk = 1'b0;
    logic           rst_n;
    logic [NE*5-1:0] evt_pulse;
    logic           wr_en;
    logic [AW-1:0]  addr;
    logic [31:0]    wdata;
    logic [31:0]    rdata;
    logic           irq_o;

    int vectors = 0;
    int fails   = 0;
    logic [31:0] raw_m  = '0;
    logic [31:0] mask_m = '0;
    logic        irq_m  = 1'b0;

    evtirq_ctrl #(.NUM_ENG(NE), .ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq_o(irq_o)
    );

    always #4 clk = ~clk;

    // Event vector to status bit positions (engine i, code j -> i*8+j).
    function automatic logic [31:0] spread(input logic [NE*5-1:0] e);
        logic [31:0] w = '0;
        for (int i = 0; i < NE; i++) w[i*8 +: 5] = e[i*5 +: 5];
        return w;
    endfunction

    // Expected read data for an offset.
    function automatic logic [31:0] exp_read(input logic [AW-1:0] a);
        case (a)
            5'h08:   return raw_m;
            5'h0C:   return raw_m & mask_m;
            5'h10:   return mask_m;
            default: return '0;
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One clock: drive, update the model, then sample at the falling edge.
    task automatic step(input logic [NE*5-1:0] e, input logic w,
                        input logic [AW-1:0] a, input logic [31:0] d, input string req);
        logic [31:0] nraw;
        logic [31:0] nmask;
        evt_pulse = e; wr_en = w; addr = a; wdata = d;
        nraw  = raw_m;
        nmask = mask_m;
        if (w && a == 5'h08) nraw = nraw & ~d;
        nraw = (nraw | spread(e)) & IMPL;
        if (w && a == 5'h10) nmask = d & IMPL;
        @(posedge clk);
        irq_m  = |(raw_m & mask_m);
        raw_m  = nraw;
        mask_m = nmask;
        @(negedge clk);
        evt_pulse = '0; wr_en = 1'b0;
        chk(req, rdata, exp_read(addr));
        chk("R7 irq", {31'b0, irq_o}, {31'b0, irq_m});
    endtask

    task automatic peek(input logic [AW-1:0] a, input string req, input logic [31:0] exp);
        addr = a; #1;
        chk(req, rdata, exp);
    endtask

    initial begin
        #(8 * 100000);
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        logic [AW-1:0] alist [5];
        int unused;
        alist[0] = 5'h08; alist[1] = 5'h0C; alist[2] = 5'h10;
        alist[3] = 5'h04; alist[4] = 5'h14;
        unused = $urandom(32'd1234);
        rst_n = 1'b0; evt_pulse = '0; wr_en = 1'b0; addr = 5'h08; wdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1 reset state
        peek(5'h08, "R1 status", 32'h0);
        peek(5'h10, "R1 mask", 32'h0);
        chk("R1 irq", {31'b0, irq_o}, 32'h0);

        // R2: each event of engine 1 code 3 (bit 11) and engine 0 code 0
        step(10'b01000_00001, 1'b0, 5'h08, 32'h0, "R2 set");
        peek(5'h08, "R2 sticky", 32'h0000_0801);
        // R6: zero mask keeps irq low; R5 view is zero
        step('0, 1'b0, 5'h0C, 32'h0, "R5 view zero");
        chk("R6 irq off", {31'b0, irq_o}, 32'h0);
        // R3 partial clear of bit 0
        step('0, 1'b1, 5'h08, 32'h0000_0001, "R3 clear");
        peek(5'h08, "R3 partial", 32'h0000_0800);
        // R4 set and clear of bit 11 in the same cycle
        step(10'b01000_00000, 1'b1, 5'h08, 32'h0000_0800, "R4 collide");
        peek(5'h08, "R4 set wins", 32'h0000_0800);
        // R6 mask write, unimplemented bits dropped; R5 masked view
        step('0, 1'b1, 5'h10, 32'hFFFF_FFFF, "R6 mask");
        peek(5'h10, "R8 mask impl", 32'h0000_1F1F);
        peek(5'h0C, "R5 view", 32'h0000_0800);
        step('0, 1'b0, 5'h08, 32'h0, "R7 idle");
        chk("R7 irq high", {31'b0, irq_o}, 32'h1);
        // R9 writes to the view and to an unmapped offset change nothing
        step('0, 1'b1, 5'h0C, 32'hFFFF_FFFF, "R9 view wr");
        step('0, 1'b1, 5'h04, 32'hFFFF_FFFF, "R9 unmapped wr");
        peek(5'h08, "R9 status kept", 32'h0000_0800);
        peek(5'h14, "R9 unmapped rd", 32'h0);
        // R8 clear-all pattern
        step(10'b11111_11111, 1'b0, 5'h08, 32'h0, "R2 all");
        step('0, 1'b1, 5'h08, 32'hFF00_1F1F, "R8 clear-all");
        peek(5'h08, "R8 cleared", 32'h0);

        // Random traffic
        for (int n = 0; n < 3000; n++) begin
            logic [NE*5-1:0] e;
            for (int b = 0; b < NE*5; b++) e[b] = ($urandom % 8) == 0;
            step(e, ($urandom % 3) == 0, alist[$urandom % 5], $urandom, "R2/R3/R5 random");
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule